// File: doc/BRIEF.md
# Successive-Approximation Conversion and Readout Controller

This block is the digital core of a successive-approximation analog-to-digital converter. It decides when a conversion starts and how long it runs. It steps a trial code out to an external DAC one bit per clock and takes the comparator's verdict on each trial. When the conversion finishes, it holds the result in a register. A host reaches the block through a select pair (enable high, select low), a read/convert line and a byte-address line. A word-format input chooses between one 12-bit word and two bytes, and a mode input chooses between level-controlled operation and edge-started operation.

When a conversion starts, the byte-address line picks its length: a full 12-bit pass or an 8-bit pass. On a read, the stored result appears on a 12-bit bus made of three nibbles. Each nibble has its own output enable, so the bus can be tri-stated by surrounding logic. The bus carries either the full word, or the upper byte, or a low byte in which the middle nibble is forced to zero.

Top module: `sar_ctl_top`

## Requirements
- R1: No conversion starts and no read takes place unless `chip_en_i` is 1 and `chip_sel_n_i` is 0 in the same cycle.
- R2: With `standalone_i` = 0, a selected cycle with `rd_conv_i` = 0 starts a conversion. `busy_o` is 1 right after that clock edge.
- R3: With `standalone_i` = 1, a conversion starts only on a selected cycle where `rd_conv_i` is 0 and was 1 in the cycle before. Holding `rd_conv_i` low starts nothing further.
- R4: A conversion started with `byte_addr_i` = 0 resolves all 12 bits. `busy_o` stays high for exactly 12 cycles, and the result is the largest code whose DAC value the comparator reports as at or below the input.
- R5: A conversion started with `byte_addr_i` = 1 resolves only bits 11..4. `busy_o` stays high for exactly 8 cycles, and result bits 3..0 are 0.
- R6: `busy_o` is 1 from the clock edge that starts a conversion until the edge that completes it, and 0 otherwise.
- R7: A start request while `busy_o` is 1 is ignored, and its byte-address value does not change the conversion length. The stored result changes only when a conversion completes, so a read taken mid-conversion returns the previous result.
- R8: With `word12_i` = 1, a selected read with `rd_conv_i` = 1 sets `nib_oe_o` = 3'b111 and `data_o` = result, one cycle later.
- R9: With `word12_i` = 0 and `byte_addr_i` = 0, a read gives `nib_oe_o` = 3'b110 and `data_o[11:4]` = result[11:4], with `data_o[3:0]` = 0.
- R10: With `word12_i` = 0 and `byte_addr_i` = 1, a read gives `nib_oe_o` = 3'b011 and `data_o` = {4'h0, 4'h0, result[3:0]}.
- R11: One cycle after any cycle without a selected read, `nib_oe_o` = 0 and `data_o` = 0. This also holds after reset.
- R12: Trials run from the MSB down. In the first busy cycle `dac_o` = 12'h800. Each trial bit is kept if `cmp_i` = 1 (DAC at or below the input) and cleared otherwise.

`nib_oe_o` bit 2 enables `data_o[11:8]`, bit 1 enables `data_o[7:4]` and bit 0 enables `data_o[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_sel_n_i | input | 1 | Chip select, active low |
| rd_conv_i | input | 1 | 1 = read, 0 = convert (level in full-control mode, falling edge in stand-alone mode) |
| byte_addr_i | input | 1 | Start: 1 = short 8-bit pass. Byte read: 1 = low byte |
| word12_i | input | 1 | 1 = single 12-bit word, 0 = two bytes |
| standalone_i | input | 1 | 1 = edge-started mode, 0 = full-control mode |
| cmp_i | input | 1 | Comparator: 1 when DAC value is at or below the input |
| dac_o | output | 12 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | 12 | Output data bus |
| nib_oe_o | output | 3 | Per-nibble output enables |

## Verification
A start request is sampled on a clock edge, and `busy_o` and the first trial code appear right after that edge. The bench samples them 1 ns after the edge and then counts busy cycles until `busy_o` falls, expecting 12 or 8. Read data and enables come out of registers one cycle after the sampled read request, so every bus check samples after the next edge. A second check one edge after deselection confirms that the bus has gone idle. Comparator answers come from a bench model that compares `dac_o` with the chosen input value, and the expected results come from that same value.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
    parameter int unsigned RES_W      = 12;
    parameter int unsigned NIB_W      = 4;
    parameter int unsigned SHORT_BITS = 8;
    parameter int unsigned NIBS       = RES_W / NIB_W;
    parameter int unsigned IDX_W      = $clog2(RES_W);

    typedef logic [RES_W-1:0] code_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic conv;
        logic rd;
    } req_t;

    typedef struct packed {
        logic [NIBS-1:0] oe;
        code_t           data;
    } bus_t;

    function automatic code_t bit_mask(input idx_t idx);
        return code_t'(1) << idx;
    endfunction
endpackage

// File: rtl/sar_req_decode.sv
module sar_req_decode
    import sar_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chip_en_i,
    input  logic chip_sel_n_i,
    input  logic rd_conv_i,
    input  logic standalone_i,
    output req_t req_o
);
    logic rc_q;
    logic sel;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) rc_q <= 1'b0;
        else     rc_q <= rd_conv_i;
    end

    always_comb begin
        sel        = chip_en_i && !chip_sel_n_i;
        fall       = rc_q && !rd_conv_i;
        req_o.rd   = sel && rd_conv_i;
        req_o.conv = sel && (standalone_i ? fall : !rd_conv_i);
    end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  short_i,
    input  logic  cmp_i,
    output code_t dac_o,
    output logic  busy_o,
    output code_t result_o
);
    localparam idx_t TOP_IDX   = idx_t'(RES_W - 1);
    localparam idx_t FULL_STOP = idx_t'(0);
    localparam idx_t SHORT_STP = idx_t'(RES_W - SHORT_BITS);

    eng_state_e state_q;
    code_t      trial_q;
    code_t      res_q;
    code_t      kept;
    idx_t       idx_q;
    idx_t       stop_q;

    always_comb begin
        kept = cmp_i ? trial_q : (trial_q & ~bit_mask(idx_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            trial_q <= '0;
            res_q   <= '0;
            idx_q   <= '0;
            stop_q  <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        state_q <= ENG_RUN;
                        trial_q <= bit_mask(TOP_IDX);
                        idx_q   <= TOP_IDX;
                        stop_q  <= short_i ? SHORT_STP : FULL_STOP;
                    end
                end
                ENG_RUN: begin
                    if (idx_q == stop_q) begin
                        trial_q <= kept;
                        res_q   <= kept;
                        state_q <= ENG_IDLE;
                    end else begin
                        trial_q <= kept | bit_mask(idx_q - idx_t'(1));
                        idx_q   <= idx_q - idx_t'(1);
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign dac_o    = trial_q;
    assign busy_o   = (state_q == ENG_RUN);
    assign result_o = res_q;
endmodule

// File: rtl/sar_out_fmt.sv
module sar_out_fmt
    import sar_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_i,
    input  logic            wide_i,
    input  logic            low_byte_i,
    input  code_t           result_i,
    output logic [NIBS-1:0] oe_o,
    output code_t           data_o
);
    bus_t bus_d;
    bus_t bus_q;

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        localparam bit IN_HI = (n >= NIBS - 2);
        localparam bit IN_LO = (n < 2);
        localparam bit IS_LSN = (n == 0);
        logic en;
        logic pass;
        always_comb begin
            en   = wide_i || (low_byte_i ? IN_LO : IN_HI);
            pass = wide_i || !low_byte_i || IS_LSN;
            bus_d.oe[n] = rd_i && en;
            bus_d.data[n*NIB_W +: NIB_W] =
                (rd_i && en && pass) ? result_i[n*NIB_W +: NIB_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_q <= '0;
        else     bus_q <= bus_d;
    end

    assign oe_o   = bus_q.oe;
    assign data_o = bus_q.data;
endmodule

// File: rtl/sar_ctl_top.sv
module sar_ctl_top
    import sar_ctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      chip_en_i,
    input  logic                      chip_sel_n_i,
    input  logic                      rd_conv_i,
    input  logic                      byte_addr_i,
    input  logic                      word12_i,
    input  logic                      standalone_i,
    input  logic                      cmp_i,
    output logic [RES_W-1:0]          dac_o,
    output logic                      busy_o,
    output logic [RES_W-1:0]          data_o,
    output logic [NIBS-1:0]           nib_oe_o
);
    req_t  req;
    code_t result_w;
    logic  start;

    sar_req_decode u_dec (
        .clk          (clk),
        .rst          (rst),
        .chip_en_i    (chip_en_i),
        .chip_sel_n_i (chip_sel_n_i),
        .rd_conv_i    (rd_conv_i),
        .standalone_i (standalone_i),
        .req_o        (req)
    );

    assign start = req.conv;

    sar_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .short_i  (byte_addr_i),
        .cmp_i    (cmp_i),
        .dac_o    (dac_o),
        .busy_o   (busy_o),
        .result_o (result_w)
    );

    sar_out_fmt u_fmt (
        .clk        (clk),
        .rst        (rst),
        .rd_i       (req.rd),
        .wide_i     (word12_i),
        .low_byte_i (byte_addr_i),
        .result_i   (result_w),
        .oe_o       (nib_oe_o),
        .data_o     (data_o)
    );
endmodule

// File: rtl/sar_ctl_chk.sv
module sar_ctl_chk
    import sar_ctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            chip_en_i,
    input logic            chip_sel_n_i,
    input logic            rd_conv_i,
    input logic            byte_addr_i,
    input logic            word12_i,
    input logic            busy_o,
    input code_t           dac_o,
    input code_t           data_o,
    input logic [NIBS-1:0] nib_oe_o,
    input code_t           res_q
);
    logic sel;
    assign sel = chip_en_i && !chip_sel_n_i;

    // R1
    unselected_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !sel) |=> !busy_o);

    // R12
    first_trial_msb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (dac_o == code_t'(1) << (RES_W - 1)));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (!busy_o || $stable(res_q)));

    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel && rd_conv_i) |=> (nib_oe_o == '0 && data_o == '0));

    // R8
    wide_read_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_conv_i && word12_i) |=> ($countones(nib_oe_o) == NIBS));

    // R9
    high_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_conv_i && !word12_i && !byte_addr_i) |=> (nib_oe_o == 3'b110));

    // R10
    low_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_conv_i && !word12_i && byte_addr_i) |=>
            (nib_oe_o == 3'b011 && data_o[7:4] == 4'h0));
endmodule

bind sar_ctl_top sar_ctl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .chip_en_i    (chip_en_i),
    .chip_sel_n_i (chip_sel_n_i),
    .rd_conv_i    (rd_conv_i),
    .byte_addr_i  (byte_addr_i),
    .word12_i     (word12_i),
    .busy_o       (busy_o),
    .dac_o        (dac_o),
    .data_o       (data_o),
    .nib_oe_o     (nib_oe_o),
    .res_q        (result_w)
);

// File: tb/sar_ctl_top_tb_top.sv
`timescale 1ns/1ps
module sar_ctl_top_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic ce, cs_n, rc, a0, w12, sa;
    logic cmp;
    logic [11:0] dac, data;
    logic [2:0]  oe;
    logic busy;
    logic [11:0] vin;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign cmp = (dac <= vin);

    sar_ctl_top dut_i (
        .clk(clk), .rst(rst), .chip_en_i(ce), .chip_sel_n_i(cs_n),
        .rd_conv_i(rc), .byte_addr_i(a0), .word12_i(w12),
        .standalone_i(sa), .cmp_i(cmp), .dac_o(dac), .busy_o(busy),
        .data_o(data), .nib_oe_o(oe)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_res(input logic [11:0] v, input bit short);
        return short ? {v[11:4], 4'h0} : v;
    endfunction

    function automatic logic [14:0] exp_bus(input logic [11:0] r, input bit wide, input bit lo);
        if (wide)    return {3'b111, r};
        else if (!lo) return {3'b110, r[11:4], 4'h0};
        else         return {3'b011, 8'h00, r[3:0]};
    endfunction

    task automatic deselect();
        @(negedge clk);
        ce = 1'b0; cs_n = 1'b1; rc = 1'b1;
    endtask

    task automatic run_conv(input bit mode, input bit a0v, input logic [11:0] v);
        int cnt;
        vin = v; sa = mode;
        if (mode) begin
            @(negedge clk); ce = 1'b1; cs_n = 1'b0; rc = 1'b1; a0 = a0v;
            @(negedge clk); rc = 1'b0;
        end else begin
            @(negedge clk); ce = 1'b1; cs_n = 1'b0; rc = 1'b0; a0 = a0v;
        end
        @(posedge clk); #1;
        check(busy == 1'b1, mode ? "R3 start" : "R2 start", busy, 1);
        check(dac == 12'h800, "R12 first trial", dac, 12'h800);
        deselect();
        cnt = 1;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (busy) cnt++;
            else break;
        end
        check(cnt == (a0v ? 8 : 12), a0v ? "R5 R6 busy length" : "R4 R6 busy length",
              cnt, a0v ? 8 : 12);
    endtask

    task automatic do_read(input bit wide, input bit lo, input logic [11:0] r);
        logic [14:0] e;
        e = exp_bus(r, wide, lo);
        @(negedge clk); ce = 1'b1; cs_n = 1'b0; rc = 1'b1; w12 = wide; a0 = lo;
        @(posedge clk); #1;
        check({oe, data} == e, wide ? "R8 word read" : (lo ? "R10 low byte" : "R9 high byte"),
              {oe, data}, e);
        deselect();
        @(posedge clk); #1;
        check(oe == 3'b000 && data == 12'h000, "R11 idle bus", {oe, data}, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] v;
        bit m, s, w, l;
        int cnt;
        void'($urandom(32'h5A17));
        rst = 1'b1; ce = 1'b0; cs_n = 1'b1; rc = 1'b1; a0 = 1'b0; w12 = 1'b1; sa = 1'b0;
        vin = 12'h000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b0, "R6 reset busy", busy, 0);
        check(oe == 3'b000 && data == 12'h000, "R11 reset bus", {oe, data}, 0);
        do_read(1'b1, 1'b0, 12'h000);

        // R1: convert/read requests while not selected
        @(negedge clk); ce = 1'b0; cs_n = 1'b0; rc = 1'b0;
        repeat (3) @(posedge clk); #1;
        check(busy == 1'b0, "R1 enable low", busy, 0);
        @(negedge clk); ce = 1'b1; cs_n = 1'b1; rc = 1'b0;
        repeat (3) @(posedge clk); #1;
        check(busy == 1'b0, "R1 select high", busy, 0);
        @(negedge clk); ce = 1'b0; cs_n = 1'b0; rc = 1'b1; w12 = 1'b1;
        @(posedge clk); #1;
        check(oe == 3'b000, "R1 unselected read", oe, 0);
        deselect();

        // Directed corners
        run_conv(1'b0, 1'b0, 12'hFFF); do_read(1'b1, 1'b0, 12'hFFF);
        run_conv(1'b0, 1'b0, 12'h000); do_read(1'b1, 1'b0, 12'h000);
        run_conv(1'b0, 1'b1, 12'hA5F); do_read(1'b1, 1'b0, 12'hA50);
        do_read(1'b0, 1'b1, 12'hA50);
        run_conv(1'b1, 1'b0, 12'h7C3); do_read(1'b0, 1'b0, 12'h7C3);
        do_read(1'b0, 1'b1, 12'h7C3);

        // R3: hold read/convert low in stand-alone mode, no second start
        vin = 12'h321; sa = 1'b1;
        @(negedge clk); ce = 1'b1; cs_n = 1'b0; rc = 1'b1; a0 = 1'b1;
        @(negedge clk); rc = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b1, "R3 edge start", busy, 1);
        repeat (12) @(posedge clk); #1;
        check(busy == 1'b0, "R3 level low no restart", busy, 0);
        repeat (4) @(posedge clk); #1;
        check(busy == 1'b0, "R3 level low no restart late", busy, 0);
        deselect();
        do_read(1'b1, 1'b0, 12'h320);

        // R7: restart ignored, mid-conversion read returns previous result
        run_conv(1'b0, 1'b0, 12'h123);
        vin = 12'hABC; sa = 1'b0;
        @(negedge clk); ce = 1'b1; cs_n = 1'b0; rc = 1'b0; a0 = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b1, "R2 start", busy, 1);
        @(negedge clk); a0 = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk); rc = 1'b1; w12 = 1'b1; a0 = 1'b0;
        @(posedge clk); #1;
        check(busy == 1'b1, "R7 still busy", busy, 1);
        check(oe == 3'b111 && data == 12'h123, "R7 old result", {oe, data}, {3'b111, 12'h123});
        deselect();
        cnt = 4;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            if (busy) cnt++;
            else break;
        end
        check(cnt == 12, "R7 length kept", cnt, 12);
        @(posedge clk); #1;
        check(busy == 1'b0, "R7 no restart", busy, 0);
        do_read(1'b1, 1'b0, 12'hABC);

        // Random mix
        for (int k = 0; k < 24; k++) begin
            v = 12'($urandom);
            m = 1'($urandom); s = 1'($urandom);
            w = 1'($urandom); l = 1'($urandom);
            run_conv(m, s, v);
            do_read(w, l, exp_res(v, s));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule